// File: doc/BRIEF.md
# PCI Initiator Burst Termination Controller

This block is the initiator side of a simplified 32-bit PCI-style bus. It runs the control part of a burst and leaves out the address and data lanes. A start request with a word count launches a one-cycle address phase, and the controller then drives FRAME# and IRDY# through as many data phases as it needs. On every clock it samples the target's DEVSEL#, TRDY# and STOP# lines. It counts the words that actually move across the bus and works out why the transaction ended.

There are four ways a transaction can end:

- **Normal completion:** every requested word moved.
- **Disconnect:** the target asserted STOP# while it was still selected.
- **Target abort:** the target dropped its select and raised STOP# without moving data.
- **Master abort:** no target claimed the cycle within a fixed number of data clocks.

At the end the block gives a one-cycle done pulse, a two-bit termination code, the number of words moved, and a bus-error flag. Software or a higher layer reads these and decides what to do next. The block never retries on its own.

Top module: `pci_init_term`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs take these values: `frame_n` and `irdy_n` high, `done` low, `status` 00, `xfer_count` 0 and `bus_err` low.
- R2: A `start` sampled in idle with a nonzero `burst_len` pulls `frame_n` low on that edge. `irdy_n` goes low one edge later. A `start` with `burst_len` equal to 0 is ignored and the bus stays idle.
- R3: A word is counted only on an edge where `irdy_n` and `trdy_n` are both low. Data phases where `trdy_n` is high are wait states and leave the count unchanged.
- R4: `frame_n` goes high while `irdy_n` stays low for the final data phase. After the final phase ends, `irdy_n` goes high and `done` is high for exactly one cycle.
- R5: A burst that moves all `burst_len` words ends with status 00 and `xfer_count` equal to `burst_len`.
- R6: Suppose `stop_n` is seen low with `devsel_n` low while `frame_n` is low. Then `frame_n` stays low through the following data phase and goes high only for the phase after it. The transaction ends with status 01 when fewer than `burst_len` words moved.
- R7: During a disconnect, the target may hold `stop_n` low with `trdy_n` high for extra data phases. The controller keeps waiting, counts no word for those phases, and ends cleanly.
- R8: Suppose `stop_n` is low, `devsel_n` is high and `trdy_n` is high in a data phase. That is a target abort: `frame_n` and `irdy_n` are both released at once, status becomes 10 and `bus_err` is set. No new transaction starts without a fresh `start`.
- R9: Suppose `devsel_n` has never been low and is still high on the DEVSEL_TIMEOUT-th data-phase edge. The transaction then ends as a master abort with status 11 and `bus_err` set. A select seen on that edge or earlier avoids the abort.
- R10: `status`, `xfer_count` and `bus_err` hold their values from the end of a transaction until the next accepted `start`. `bus_err` is high exactly when the status code has its upper bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a burst, sampled in idle |
| burst_len | input | LEN_W | Number of words requested; 0 is ignored |
| devsel_n | input | 1 | Target select, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop request, active low |
| frame_n | output | 1 | Initiator frame, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| done | output | 1 | One-cycle pulse when a transaction ends |
| status | output | 2 | Termination code: 00 normal, 01 disconnect, 10 target abort, 11 master abort |
| xfer_count | output | LEN_W | Words moved in the last or current transaction |
| bus_err | output | 1 | Set by target or master abort |

## Verification
The bench builds the block with LEN_W of 6 and a DEVSEL_TIMEOUT of 5. With a timeout that short, the bench can drive a master abort and a select that arrives on the very last allowed edge within a few cycles. With a 6-bit length field, it can run bursts of up to 63 words, which is long enough for a disconnect to land in the middle of a burst and leave a partial count. A behavioural target driven from phase indices produces wait states, a stop with and without data, and an abort in a chosen phase. It also logs `frame_n` for each phase, so the one-phase hold after a stop can be checked directly.

// File: rtl/pci_term_pkg.sv
// Shared types for the initiator termination controller.
// Assumes: two-bit termination code consumed by upstream logic.
package pci_term_pkg;

    // Termination code reported on status; upper bit marks an error.
    typedef enum logic [1:0] {
        TERM_OK     = 2'b00,
        TERM_DISC   = 2'b01,
        TERM_TABORT = 2'b10,
        TERM_MABORT = 2'b11
    } term_code_t;

    // Controller sequencing states.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'b00,
        SEQ_ADDR = 2'b01,
        SEQ_DATA = 2'b10
    } seq_state_t;

endpackage

// File: rtl/pit_devsel_watch.sv
// Select watchdog: counts data-phase edges until the target claims the
// cycle, and flags a master abort on the TIMEOUT-th edge without a claim.
// Assumes: TIMEOUT >= 1; arm is pulsed when a burst is accepted.
module pit_devsel_watch #(
    parameter int TIMEOUT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic active,
    input  logic devsel_n,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] LAST_TICK = TW'(TIMEOUT - 1);
    localparam logic [TW-1:0] MAX_TICK  = TW'(TIMEOUT);

    logic [TW-1:0] ticks;
    logic          seen;

    // Track whether the target has claimed and how long we have waited.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ticks <= '0;
            seen  <= 1'b0;
        end else if (arm) begin
            ticks <= '0;
            seen  <= 1'b0;
        end else if (active) begin
            if (!devsel_n) begin
                seen <= 1'b1;
            end else if (!seen && ticks != MAX_TICK) begin
                ticks <= ticks + 1'b1;
            end
        end
    end

    // Abort decision for the edge under way.
    always_comb begin
        expired = active && !seen && devsel_n && (ticks == LAST_TICK);
    end
endmodule

// File: rtl/pit_beat_count.sv
// Word counter: accumulates completed transfers of one burst.
// Assumes: xfer is only raised during data phases; count never exceeds
// the requested length, so LEN_W bits are enough.
module pit_beat_count #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             xfer,
    output logic [LEN_W-1:0] count,
    output logic [LEN_W-1:0] count_next
);
    // Count value once the current edge's transfer is included.
    always_comb begin
        count_next = count + LEN_W'(xfer);
    end

    // Register the running count; cleared when a burst is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else begin
            count <= count_next;
        end
    end
endmodule

// File: rtl/pit_term_fsm.sv
// Termination sequencer: drives FRAME#/IRDY#, decides the final phase,
// and classifies the end of each transaction.
// Assumes: the address phase lasts one cycle; IRDY# stays asserted for
// every data phase (the initiator never inserts wait states).
module pit_term_fsm
    import pci_term_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] burst_len,
    input  logic             devsel_n,
    input  logic             trdy_n,
    input  logic             stop_n,
    input  logic             expired,
    input  logic [LEN_W-1:0] count_next,
    output logic             accept,
    output logic             in_data,
    output logic             xfer,
    output logic             frame_n,
    output logic             irdy_n,
    output logic             done,
    output term_code_t       status,
    output logic             bus_err
);
    seq_state_t       state;
    logic [LEN_W-1:0] len_q;
    logic             stop_seen;
    logic             tgt_abort;
    logic             disc_req;
    logic             all_moved;
    logic             one_left;

    // Decode the target's response for the edge under way.
    always_comb begin
        accept    = (state == SEQ_IDLE) && start && (burst_len != '0);
        in_data   = (state == SEQ_DATA);
        xfer      = in_data && !trdy_n;
        tgt_abort = in_data && !stop_n && devsel_n && trdy_n;
        disc_req  = !stop_n && !devsel_n;
        all_moved = (count_next == len_q);
        one_left  = (count_next == len_q - LEN_W'(1));
    end

    // Sequence the bus phases and record the termination result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            frame_n   <= 1'b1;
            irdy_n    <= 1'b1;
            len_q     <= '0;
            stop_seen <= 1'b0;
            done      <= 1'b0;
            status    <= TERM_OK;
            bus_err   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        state     <= SEQ_ADDR;
                        len_q     <= burst_len;
                        frame_n   <= 1'b0;
                        stop_seen <= 1'b0;
                        status    <= TERM_OK;
                        bus_err   <= 1'b0;
                    end
                end
                SEQ_ADDR: begin
                    state   <= SEQ_DATA;
                    irdy_n  <= 1'b0;
                    frame_n <= (len_q == LEN_W'(1));
                end
                SEQ_DATA: begin
                    if (tgt_abort) begin
                        state   <= SEQ_IDLE;
                        frame_n <= 1'b1;
                        irdy_n  <= 1'b1;
                        done    <= 1'b1;
                        status  <= TERM_TABORT;
                        bus_err <= 1'b1;
                    end else if (expired) begin
                        state   <= SEQ_IDLE;
                        frame_n <= 1'b1;
                        irdy_n  <= 1'b1;
                        done    <= 1'b1;
                        status  <= TERM_MABORT;
                        bus_err <= 1'b1;
                    end else if (frame_n) begin
                        if (xfer || !stop_n) begin
                            state  <= SEQ_IDLE;
                            irdy_n <= 1'b1;
                            done   <= 1'b1;
                            status <= all_moved ? TERM_OK : TERM_DISC;
                        end
                    end else if (xfer && one_left) begin
                        frame_n <= 1'b1;
                    end else if (stop_seen) begin
                        frame_n <= 1'b1;
                    end else if (disc_req) begin
                        stop_seen <= 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pci_init_term.sv
// Top of the initiator burst termination controller. Connects the
// sequencer, the word counter and the select watchdog.
// Assumes: target lines are synchronous to clk; reset is synchronous.
module pci_init_term
    import pci_term_pkg::*;
#(
    parameter int LEN_W          = 8,
    parameter int DEVSEL_TIMEOUT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] burst_len,
    input  logic             devsel_n,
    input  logic             trdy_n,
    input  logic             stop_n,
    output logic             frame_n,
    output logic             irdy_n,
    output logic             done,
    output logic [1:0]       status,
    output logic [LEN_W-1:0] xfer_count,
    output logic             bus_err
);
    logic             accept;
    logic             in_data;
    logic             xfer;
    logic             expired;
    logic [LEN_W-1:0] count_next;
    term_code_t       code;

    pit_term_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .burst_len  (burst_len),
        .devsel_n   (devsel_n),
        .trdy_n     (trdy_n),
        .stop_n     (stop_n),
        .expired    (expired),
        .count_next (count_next),
        .accept     (accept),
        .in_data    (in_data),
        .xfer       (xfer),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .done       (done),
        .status     (code),
        .bus_err    (bus_err)
    );

    pit_beat_count #(.LEN_W(LEN_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .xfer       (xfer),
        .count      (xfer_count),
        .count_next (count_next)
    );

    pit_devsel_watch #(.TIMEOUT(DEVSEL_TIMEOUT)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (accept),
        .active   (in_data),
        .devsel_n (devsel_n),
        .expired  (expired)
    );

    // Present the termination code as a plain vector.
    always_comb begin
        status = code;
    end
endmodule

// File: rtl/pit_checker.sv
// Protocol checker for pci_init_term, attached through bind.
// Assumes: observes only the top-level ports.
module pit_checker #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_n,
    input logic             irdy_n,
    input logic             done,
    input logic [1:0]       status,
    input logic [LEN_W-1:0] xfer_count,
    input logic             bus_err
);
    // R1: bus released in the cycle following reset.
    assert_idle_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (frame_n && irdy_n && !done));

    // R4: done never lasts more than one cycle.
    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: frame released ahead of the end keeps irdy asserted.
    assert_frame_before_irdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frame_n) && !done) |-> !irdy_n);

    // R4: irdy is released only when the transaction ends.
    assert_irdy_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irdy_n) |-> done);

    // R10: error flag tracks the upper bit of the code at completion.
    assert_err_matches_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_err == status[1]));

    // R8: no automatic retry after an abort.
    assert_no_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status[1]) |=> (frame_n && irdy_n));

    // R10: results stay put while the bus is idle.
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_n) && $past(irdy_n) && frame_n && irdy_n && !done)
        |-> ($stable(status) && $stable(xfer_count) && $stable(bus_err)));
endmodule

bind pci_init_term pit_checker #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .done       (done),
    .status     (status),
    .xfer_count (xfer_count),
    .bus_err    (bus_err)
);

// File: tb/pci_init_term_test.sv
`timescale 1ns/1ps
module pci_init_term_test;
    localparam int LEN_W = 6;
    localparam int TMO   = 5;

    typedef struct {
        logic [1:0]       status;
        logic [LEN_W-1:0] count;
        logic             err;
        int               phases;
        string            req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] burst_len = '0;
    logic             devsel_n = 1'b1;
    logic             trdy_n = 1'b1;
    logic             stop_n = 1'b1;
    logic             frame_n;
    logic             irdy_n;
    logic             done;
    logic [1:0]       status;
    logic [LEN_W-1:0] xfer_count;
    logic             bus_err;

    int checks = 0;
    int fails  = 0;
    exp_t sb[$];

    // target model controls, indexed by data phase
    int          ph = 0;
    int          dv_start = 0;
    logic [31:0] trdy_mask = '1;
    int          stop_from = 999;
    int          abort_at = 999;
    logic        frame_log[32];

    pci_init_term #(.LEN_W(LEN_W), .DEVSEL_TIMEOUT(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .burst_len(burst_len),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .frame_n(frame_n), .irdy_n(irdy_n), .done(done), .status(status),
        .xfer_count(xfer_count), .bus_err(bus_err)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Target responder: drives the lines for the next data phase.
    always @(negedge clk) begin
        if (!irdy_n) begin
            if (ph < 32) frame_log[ph] = frame_n;
            if (ph >= abort_at) begin
                devsel_n = 1'b1; stop_n = 1'b0; trdy_n = 1'b1;
            end else begin
                devsel_n = !(ph >= dv_start);
                trdy_n   = !((ph >= dv_start) && (ph < 32) && trdy_mask[ph]);
                stop_n   = !((ph >= dv_start) && (ph >= stop_from));
            end
            ph = ph + 1;
        end else begin
            devsel_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1;
        end
    end

    // Monitor: pops expected results when the design reports completion.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R4", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(status == e.status, e.req, "status", int'(status), int'(e.status));
                chk(xfer_count == e.count, e.req, "count", int'(xfer_count), int'(e.count));
                chk(bus_err == e.err, e.req, "bus_err", int'(bus_err), int'(e.err));
                chk(ph == e.phases, e.req, "data phases", ph, e.phases);
            end
        end
    end

    // Driver: configures the target, queues the expectation, starts a burst.
    task automatic run(input int len, input int dvs, input logic [31:0] mask,
                       input int sfrom, input int abat, input logic [1:0] est,
                       input int ecnt, input logic eerr, input int eph,
                       input string req);
        exp_t e;
        dv_start = dvs; trdy_mask = mask; stop_from = sfrom; abort_at = abat;
        ph = 0;
        e.status = est; e.count = LEN_W'(ecnt); e.err = eerr;
        e.phases = eph; e.req = req;
        sb.push_back(e);
        start = 1'b1; burst_len = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(frame_n && irdy_n, "R1", "bus lines idle", int'({frame_n, irdy_n}), 3);
        chk(!done && status == 2'b00, "R1", "done/status", int'({done, status}), 0);
        chk(xfer_count == 0 && !bus_err, "R1", "count/err", int'(xfer_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: zero length ignored
        start = 1'b1; burst_len = '0;
        @(negedge clk);
        start = 1'b0;
        repeat (3) begin
            chk(frame_n && irdy_n, "R2", "zero length ignored", int'({frame_n, irdy_n}), 3);
            @(negedge clk);
        end

        // R2: phase timing after start
        fork
            run(4, 0, '1, 999, 999, 2'b00, 4, 1'b0, 4, "R5");
            begin
                @(negedge clk);
                chk(!frame_n && irdy_n, "R2", "address phase", int'({frame_n, irdy_n}), 1);
                @(negedge clk);
                chk(!frame_n && !irdy_n, "R2", "first data phase", int'({frame_n, irdy_n}), 0);
            end
        join
        // R4: frame high only on final phase of the 4-word burst
        chk(frame_log[2] == 1'b0, "R4", "frame before last", int'(frame_log[2]), 0);
        chk(frame_log[3] == 1'b1, "R4", "frame on last", int'(frame_log[3]), 1);

        // R3: wait states on phases 1 and 3
        run(3, 0, 32'b10101, 999, 999, 2'b00, 3, 1'b0, 5, "R3");

        // R6: disconnect with data, frame held one more phase
        run(8, 0, '1, 2, 999, 2'b01, 5, 1'b0, 5, "R6");
        chk(frame_log[3] == 1'b0, "R6", "frame held after stop", int'(frame_log[3]), 0);
        chk(frame_log[4] == 1'b1, "R6", "frame released next", int'(frame_log[4]), 1);

        // R7: stop held without trdy
        run(8, 0, 32'b11, 2, 999, 2'b01, 2, 1'b0, 5, "R7");

        // R8: target abort in phase 2
        run(6, 0, '1, 999, 2, 2'b10, 2, 1'b1, 3, "R8");
        repeat (4) @(negedge clk);
        chk(frame_n && irdy_n, "R8", "no retry", int'({frame_n, irdy_n}), 3);
        chk(status == 2'b10 && bus_err, "R10", "abort result held", int'(status), 2);

        // R9: master abort, never selected
        run(4, 999, '1, 999, 999, 2'b11, 0, 1'b1, TMO, "R9");

        // R9: select on the last allowed edge, single word
        run(1, TMO - 1, '1, 999, 999, 2'b00, 1, 1'b0, TMO, "R9");

        // R5: single-word burst
        run(1, 0, '1, 999, 999, 2'b00, 1, 1'b0, 1, "R5");
        // R10: new start clears previous error
        chk(!bus_err, "R10", "error cleared", int'(bus_err), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule